// File: doc/BRIEF.md
# Device Error Signaling Gate

This block sits beside a device function's error detectors. It accepts at most one error event per cycle. Each event is a status word in one of two spaces, correctable or uncorrectable, and must carry exactly one supported bit. For each event the block works out three things. The first is the device-status bits to set: correctable detected, non-fatal detected, fatal detected and unsupported request detected. The second is the bits to set in the correctable and uncorrectable status registers. The third is whether an error message goes upstream, and at which severity.

The status registers themselves live outside the block, so it emits single-cycle set vectors that the register file ORs in. The gating inputs come from the surrounding configuration registers: the command-register system-error enable, the four reporting enables from device control, the correctable and uncorrectable mask registers, and the uncorrectable severity register. A build-time parameter can replace the severity register with the fixed default classification.

Some uncorrectable events classify as non-fatal and are flagged as possibly advisory. These are re-signalled as the correctable advisory-non-fatal error, and their original uncorrectable status bit is still set.

Top module: `dev_err_gate`

## Requirements
- R1: An event is accepted only if, after ANDing its status with the supported bits of its space, exactly one bit remains. The uncorrectable supported set is 0x03FFF030 and the correctable supported set is 0x0000F1C1. A rejected event, or a cycle with evt_valid_i low, gives msg_valid_o=0 and all set vectors zero. Unsupported bits alongside one supported bit are ignored.
- R2: An accepted correctable event sets dev_set_o bit 0 and sets its own bit in cor_set_o, with unc_set_o zero.
- R3: A correctable event whose bit is set in cor_mask_i still sets its status bit but sends no message.
- R4: A correctable-class message requires cor_rep_en_i. When it comes from an unsupported-request event (uncorrectable bit 20, advisory path), it also requires ur_rep_en_i.
- R5: An uncorrectable event is fatal when its bit is set in unc_sev_i. When USE_FIXED_SEV=1, unc_sev_i is ignored and the fatal set is bits 4, 5, 13, 17, 18 and 22 (0x00462030); every other uncorrectable bit is then non-fatal.
- R6: An uncorrectable event whose bit is set in unc_mask_i still sets its bit in unc_set_o but sends no message. This does not apply to the advisory path of R8.
- R7: A fatal message (msg_sev_o=2) requires serr_en_i or fat_rep_en_i. A non-fatal message (msg_sev_o=1) requires serr_en_i or nf_rep_en_i. A correctable message has msg_sev_o=0.
- R8: A non-fatal uncorrectable event with evt_adv_i=1 is signalled through the correctable path as correctable bit 13, which is gated by cor_mask_i bit 13. It also sets its original bit in unc_set_o. A fatal event ignores evt_adv_i.
- R9: An unsupported-request event (uncorrectable bit 20) with ur_rep_en_i=0 and serr_en_i=0 sends no message.
- R10: In dev_set_o, a fatal event sets bit 2 and a non-fatal event sets bit 1. An event on the correctable path, including the advisory path, sets bit 0. An unsupported-request event also sets bit 3.
- R11: All outputs are registered and appear one cycle after the event. msg_src_o carries evt_src_i when msg_valid_o is 1 and is zero otherwise. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | Error event present this cycle |
| evt_corr_i | input | 1 | Event status is in the correctable space |
| evt_adv_i | input | 1 | Non-fatal event may be advisory |
| evt_status_i | input | 32 | Event status bit (one-hot expected) |
| evt_src_i | input | SRC_W | Requester source ID |
| serr_en_i | input | 1 | Command-register system-error enable |
| cor_rep_en_i | input | 1 | Correctable reporting enable |
| nf_rep_en_i | input | 1 | Non-fatal reporting enable |
| fat_rep_en_i | input | 1 | Fatal reporting enable |
| ur_rep_en_i | input | 1 | Unsupported-request reporting enable |
| cor_mask_i | input | 32 | Correctable mask register |
| unc_mask_i | input | 32 | Uncorrectable mask register |
| unc_sev_i | input | 32 | Uncorrectable severity register (1 = fatal) |
| msg_valid_o | output | 1 | Error message strobe |
| msg_sev_o | output | 2 | 0 correctable, 1 non-fatal, 2 fatal |
| msg_src_o | output | SRC_W | Source ID of the message |
| dev_set_o | output | 4 | Device status set bits {UR, fatal, non-fatal, correctable} |
| cor_set_o | output | 32 | Correctable status bits to set |
| unc_set_o | output | 32 | Uncorrectable status bits to set |

## Verification
Every result, including the message strobe, severity, source ID and all three set vectors, is due exactly one rising edge after the event is presented. The bench drives each event on a falling edge, samples one nanosecond after the following rising edge, and compares the whole output bundle against a reference function. An idle cycle after a directed event confirms that the strobe and set vectors fall back to zero. A second instance built with the fixed severity table runs on the same inputs and is held to its own expected values.

// File: rtl/dev_err_gate_pkg.sv
package dev_err_gate_pkg;
  localparam int STAT_W = 32;
  localparam int DEV_W  = 4;
  localparam logic [STAT_W-1:0] UNC_SUPP       = 32'h03FF_F030;
  localparam logic [STAT_W-1:0] COR_SUPP       = 32'h0000_F1C1;
  localparam logic [STAT_W-1:0] UNC_FATAL_DFLT = 32'h0046_2030;
  localparam int UNC_UR_BIT  = 20;
  localparam int COR_ADV_BIT = 13;
  localparam int DEV_COR = 0;
  localparam int DEV_NF  = 1;
  localparam int DEV_FAT = 2;
  localparam int DEV_UR  = 3;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } sev_e;

  typedef struct packed {
    logic serr_en;
    logic cor_en;
    logic nf_en;
    logic fat_en;
    logic ur_en;
  } gate_cfg_t;
endpackage

// File: rtl/dev_err_qualify.sv
module dev_err_qualify
  import dev_err_gate_pkg::*;
#(
  parameter bit USE_FIXED_SEV = 1'b0
) (
  input  logic              valid_i,
  input  logic              corr_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [STAT_W-1:0] sev_i,
  output logic              ok_o,
  output logic [STAT_W-1:0] sup_o,
  output logic              ur_o,
  output logic              fatal_o
);
  logic [STAT_W-1:0] sev_eff;
  logic [STAT_W-1:0] sup;

  // variant: programmable severity register or fixed default table
  if (USE_FIXED_SEV) begin : g_fixed_sev
    assign sev_eff = UNC_FATAL_DFLT;
    logic unused_sev;
    assign unused_sev = ^sev_i;
  end else begin : g_reg_sev
    assign sev_eff = sev_i;
  end

  assign sup     = status_i & (corr_i ? COR_SUPP : UNC_SUPP);
  assign ok_o    = valid_i && (sup != '0) && ((sup & (sup - 1'b1)) == '0);
  assign sup_o   = sup;
  assign ur_o    = !corr_i && sup[UNC_UR_BIT];
  assign fatal_o = !corr_i && ((sup & sev_eff) != '0);
endmodule

// File: rtl/dev_err_route.sv
module dev_err_route
  import dev_err_gate_pkg::*;
(
  input  logic              ok_i,
  input  logic              corr_i,
  input  logic              adv_i,
  input  logic [STAT_W-1:0] sup_i,
  input  logic              ur_i,
  input  logic              fatal_i,
  input  gate_cfg_t         cfg_i,
  input  logic [STAT_W-1:0] cor_mask_i,
  input  logic [STAT_W-1:0] unc_mask_i,
  output logic              msg_v_o,
  output sev_e              sev_o,
  output logic [DEV_W-1:0]  dev_set_o,
  output logic [STAT_W-1:0] cor_set_o,
  output logic [STAT_W-1:0] unc_set_o
);
  logic              cor_path;
  logic [STAT_W-1:0] cor_bit;

  assign cor_path = corr_i || (!fatal_i && adv_i);
  assign cor_bit  = corr_i ? sup_i : (STAT_W'(1) << COR_ADV_BIT);

  always_comb begin
    msg_v_o   = 1'b0;
    sev_o     = SEV_COR;
    dev_set_o = '0;
    cor_set_o = '0;
    unc_set_o = '0;
    if (ok_i) begin
      dev_set_o[DEV_UR] = ur_i;
      if (cor_path) begin
        dev_set_o[DEV_COR] = 1'b1;
        cor_set_o          = cor_bit;
        unc_set_o          = corr_i ? '0 : sup_i;
        msg_v_o = ((cor_bit & cor_mask_i) == '0) && (!ur_i || cfg_i.ur_en) && cfg_i.cor_en;
      end else begin
        dev_set_o[DEV_FAT] = fatal_i;
        dev_set_o[DEV_NF]  = !fatal_i;
        unc_set_o          = sup_i;
        sev_o              = fatal_i ? SEV_FATAL : SEV_NONFATAL;
        msg_v_o = ((sup_i & unc_mask_i) == '0)
                && !(ur_i && !cfg_i.ur_en && !cfg_i.serr_en)
                && (cfg_i.serr_en || (fatal_i ? cfg_i.fat_en : cfg_i.nf_en));
      end
    end
  end
endmodule

// File: rtl/dev_err_gate.sv
module dev_err_gate
  import dev_err_gate_pkg::*;
#(
  parameter int SRC_W         = 16,
  parameter bit USE_FIXED_SEV = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic              evt_corr_i,
  input  logic              evt_adv_i,
  input  logic [STAT_W-1:0] evt_status_i,
  input  logic [SRC_W-1:0]  evt_src_i,
  input  logic              serr_en_i,
  input  logic              cor_rep_en_i,
  input  logic              nf_rep_en_i,
  input  logic              fat_rep_en_i,
  input  logic              ur_rep_en_i,
  input  logic [STAT_W-1:0] cor_mask_i,
  input  logic [STAT_W-1:0] unc_mask_i,
  input  logic [STAT_W-1:0] unc_sev_i,
  output logic              msg_valid_o,
  output logic [1:0]        msg_sev_o,
  output logic [SRC_W-1:0]  msg_src_o,
  output logic [DEV_W-1:0]  dev_set_o,
  output logic [STAT_W-1:0] cor_set_o,
  output logic [STAT_W-1:0] unc_set_o
);
  logic              q_ok, q_ur, q_fatal;
  logic [STAT_W-1:0] q_sup;
  gate_cfg_t         cfg;
  logic              r_msg_v;
  sev_e              r_sev;
  logic [DEV_W-1:0]  r_dev;
  logic [STAT_W-1:0] r_cor, r_unc;

  assign cfg = '{serr_en: serr_en_i, cor_en: cor_rep_en_i, nf_en: nf_rep_en_i,
                 fat_en: fat_rep_en_i, ur_en: ur_rep_en_i};

  dev_err_qualify #(.USE_FIXED_SEV(USE_FIXED_SEV)) u_qual (
    .valid_i (evt_valid_i),
    .corr_i  (evt_corr_i),
    .status_i(evt_status_i),
    .sev_i   (unc_sev_i),
    .ok_o    (q_ok),
    .sup_o   (q_sup),
    .ur_o    (q_ur),
    .fatal_o (q_fatal)
  );

  dev_err_route u_route (
    .ok_i      (q_ok),
    .corr_i    (evt_corr_i),
    .adv_i     (evt_adv_i),
    .sup_i     (q_sup),
    .ur_i      (q_ur),
    .fatal_i   (q_fatal),
    .cfg_i     (cfg),
    .cor_mask_i(cor_mask_i),
    .unc_mask_i(unc_mask_i),
    .msg_v_o   (r_msg_v),
    .sev_o     (r_sev),
    .dev_set_o (r_dev),
    .cor_set_o (r_cor),
    .unc_set_o (r_unc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_sev_o   <= 2'd0;
      msg_src_o   <= '0;
      dev_set_o   <= '0;
      cor_set_o   <= '0;
      unc_set_o   <= '0;
    end else begin
      msg_valid_o <= r_msg_v;
      msg_sev_o   <= r_msg_v ? r_sev : 2'd0;
      msg_src_o   <= r_msg_v ? evt_src_i : '0;
      dev_set_o   <= r_dev;
      cor_set_o   <= r_cor;
      unc_set_o   <= r_unc;
    end
  end
endmodule

// File: rtl/dev_err_gate_chk.sv
module dev_err_gate_chk
  import dev_err_gate_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_valid_i,
  input logic              evt_corr_i,
  input logic [STAT_W-1:0] evt_status_i,
  input logic              serr_en_i,
  input logic              ur_rep_en_i,
  input logic [STAT_W-1:0] cor_mask_i,
  input logic              msg_valid_o,
  input logic [1:0]        msg_sev_o,
  input logic [DEV_W-1:0]  dev_set_o,
  input logic [STAT_W-1:0] cor_set_o,
  input logic [STAT_W-1:0] unc_set_o
);
  // R1
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_valid_i || $countones(evt_status_i & (evt_corr_i ? COR_SUPP : UNC_SUPP)) != 1)
    |=> (!msg_valid_o && dev_set_o == '0 && cor_set_o == '0 && unc_set_o == '0));

  // R2
  set_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cor_set_o) && $onehot0(unc_set_o));

  // R3
  cor_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_corr_i && ((evt_status_i & cor_mask_i & COR_SUPP) != '0))
    |=> !msg_valid_o);

  // R9
  ur_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !evt_corr_i && evt_status_i[UNC_UR_BIT] && !ur_rep_en_i && !serr_en_i)
    |=> !msg_valid_o);

  // R10
  ur_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_set_o[DEV_UR] |-> unc_set_o[UNC_UR_BIT]);

  // R7
  fatal_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_sev_o == 2'd2) |-> dev_set_o[DEV_FAT]);

  // R11
  sev_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_sev_o != 2'd3 && dev_set_o != '0));
endmodule

bind dev_err_gate dev_err_gate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .evt_corr_i  (evt_corr_i),
  .evt_status_i(evt_status_i),
  .serr_en_i   (serr_en_i),
  .ur_rep_en_i (ur_rep_en_i),
  .cor_mask_i  (cor_mask_i),
  .msg_valid_o (msg_valid_o),
  .msg_sev_o   (msg_sev_o),
  .dev_set_o   (dev_set_o),
  .cor_set_o   (cor_set_o),
  .unc_set_o   (unc_set_o)
);

// File: tb/dev_err_gate_test.sv
`timescale 1ns/1ps
module dev_err_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_v = 0, ev_c = 0, ev_a = 0;
  logic [31:0] ev_s = 0;
  logic [15:0] ev_src = 0;
  logic        serr = 0, cen = 0, nfen = 0, fen = 0, uren = 0;
  logic [31:0] cmask = 0, umask = 0, usev = 0;

  logic        a_mv, b_mv;
  logic [1:0]  a_sv, b_sv;
  logic [15:0] a_src, b_src;
  logic [3:0]  a_dv, b_dv;
  logic [31:0] a_cs, b_cs, a_us, b_us;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dev_err_gate #(.SRC_W(16), .USE_FIXED_SEV(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(ev_v), .evt_corr_i(ev_c), .evt_adv_i(ev_a),
    .evt_status_i(ev_s), .evt_src_i(ev_src), .serr_en_i(serr), .cor_rep_en_i(cen),
    .nf_rep_en_i(nfen), .fat_rep_en_i(fen), .ur_rep_en_i(uren), .cor_mask_i(cmask),
    .unc_mask_i(umask), .unc_sev_i(usev), .msg_valid_o(a_mv), .msg_sev_o(a_sv),
    .msg_src_o(a_src), .dev_set_o(a_dv), .cor_set_o(a_cs), .unc_set_o(a_us));

  dev_err_gate #(.SRC_W(16), .USE_FIXED_SEV(1'b1)) uut_fix (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(ev_v), .evt_corr_i(ev_c), .evt_adv_i(ev_a),
    .evt_status_i(ev_s), .evt_src_i(ev_src), .serr_en_i(serr), .cor_rep_en_i(cen),
    .nf_rep_en_i(nfen), .fat_rep_en_i(fen), .ur_rep_en_i(uren), .cor_mask_i(cmask),
    .unc_mask_i(umask), .unc_sev_i(usev), .msg_valid_o(b_mv), .msg_sev_o(b_sv),
    .msg_src_o(b_src), .dev_set_o(b_dv), .cor_set_o(b_cs), .unc_set_o(b_us));

  // expected {msg_v, sev, src, dev, cor_set, unc_set}
  function automatic logic [86:0] model(bit fixed);
    logic [31:0] sup, sev, cb, cs, us;
    logic ok, ur, fat, mv;
    logic [1:0] sv;
    logic [3:0] dv;
    sup = ev_s & (ev_c ? 32'h0000_F1C1 : 32'h03FF_F030);
    ok  = ev_v && ($countones(sup) == 1);
    sev = fixed ? 32'h0046_2030 : usev;
    ur  = !ev_c && sup[20];
    fat = !ev_c && ((sup & sev) != 0);
    mv = 0; sv = 0; dv = 0; cs = 0; us = 0;
    if (ok) begin
      dv[3] = ur;
      if (ev_c || (!fat && ev_a)) begin
        cb = ev_c ? sup : 32'h0000_2000;
        dv[0] = 1; cs = cb; us = ev_c ? 32'h0 : sup;
        mv = ((cb & cmask) == 0) && (!ur || uren) && cen;
      end else begin
        dv[2] = fat; dv[1] = !fat; us = sup;
        mv = ((sup & umask) == 0) && !(ur && !uren && !serr) && (serr || (fat ? fen : nfen));
        sv = mv ? (fat ? 2'd2 : 2'd1) : 2'd0;
      end
    end
    return {mv, sv, (mv ? ev_src : 16'h0), dv, cs, us};
  endfunction

  task automatic cmp(string tag, logic [86:0] got, logic [86:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cfg(logic s, logic c, logic n, logic f, logic u);
    serr = s; cen = c; nfen = n; fen = f; uren = u;
  endtask

  task automatic ev(logic v, logic c, logic a, logic [31:0] s, logic [15:0] src, string tag);
    logic [86:0] ea, eb;
    @(negedge clk);
    ev_v = v; ev_c = c; ev_a = a; ev_s = s; ev_src = src;
    ea = model(1'b0);
    eb = model(1'b1);
    @(posedge clk);
    #1;
    cmp(tag, {a_mv, a_sv, a_src, a_dv, a_cs, a_us}, ea);
    cmp({tag, "/R5"}, {b_mv, b_sv, b_src, b_dv, b_cs, b_us}, eb);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #9 rst_n = 1'b1;
    #1;
    // R11 reset state
    cmp("R11 reset", {a_mv, a_sv, a_src, a_dv, a_cs, a_us}, 87'h0);

    cfg(0, 1, 1, 1, 1);
    // R1 rejection and masking to supported bits
    ev(1, 0, 0, 32'h0, 16'h1, "R1 zero");
    ev(1, 0, 0, 32'h30, 16'h1, "R1 multi");
    ev(1, 0, 0, 32'h2, 16'h1, "R1 unsupported");
    ev(1, 1, 0, 32'h42, 16'h1, "R1 strip");
    ev(0, 1, 0, 32'h1, 16'h1, "R1 idle");
    // R2 / R4 correctable
    ev(1, 1, 0, 32'h1, 16'hA5A5, "R2 cor");
    ev(0, 0, 0, 32'h0, 16'h0, "R11 pulse end");
    cmask = 32'h40;
    ev(1, 1, 0, 32'h40, 16'h2, "R3 cor masked");
    cmask = 0; cen = 0;
    ev(1, 1, 0, 32'h80, 16'h3, "R4 cor disabled");
    cen = 1;
    // R5 severity
    usev = 32'h10;
    ev(1, 0, 0, 32'h10, 16'h4, "R5 fatal");
    usev = 32'h0;
    ev(1, 0, 0, 32'h10, 16'h5, "R5 nonfatal");
    // R6 masked uncorrectable
    umask = 32'h1000;
    ev(1, 0, 0, 32'h1000, 16'h6, "R6 masked");
    umask = 0;
    // R7 enables
    usev = 32'h0046_2030;
    cfg(1, 0, 0, 0, 0);
    ev(1, 0, 0, 32'h20, 16'h7, "R7 fatal serr");
    cfg(0, 0, 0, 1, 0);
    ev(1, 0, 0, 32'h20, 16'h8, "R7 fatal en");
    cfg(0, 0, 1, 0, 0);
    ev(1, 0, 0, 32'h20, 16'h9, "R7 fatal blocked");
    ev(1, 0, 0, 32'h4000, 16'hA, "R7 nonfatal en");
    // R8 advisory
    cfg(0, 1, 1, 1, 1);
    umask = 32'h4000;
    ev(1, 0, 1, 32'h4000, 16'hB, "R8 advisory");
    umask = 0;
    ev(1, 0, 1, 32'h20, 16'hC, "R8 fatal not advisory");
    cmask = 32'h2000;
    ev(1, 0, 1, 32'h8000, 16'hD, "R8 advisory masked");
    cmask = 0;
    // R9 / R10 unsupported request
    cfg(0, 1, 1, 1, 0);
    ev(1, 0, 0, 32'h0010_0000, 16'hE, "R9 ur blocked");
    cfg(1, 1, 1, 1, 0);
    ev(1, 0, 0, 32'h0010_0000, 16'hF, "R10 ur serr");
    ev(1, 0, 1, 32'h0010_0000, 16'h10, "R4 advisory ur");
    ev(0, 0, 0, 32'h0, 16'h0, "R11 idle");

    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] s;
      cfg($urandom_range(0, 1), $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
          $urandom_range(0, 3) != 0, $urandom_range(0, 1));
      cmask = $urandom() & $urandom();
      umask = $urandom() & $urandom();
      usev  = $urandom();
      s = ($urandom_range(0, 7) == 0) ? $urandom() : (32'h1 << $urandom_range(0, 31));
      ev($urandom_range(0, 7) != 0, $urandom_range(0, 1), $urandom_range(0, 1), s,
         16'($urandom()), "R11 random");
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule